// File: doc/BRIEF.md
# Step Attenuator Control Latch

This block drives the seven switch-control lines of a binary-weighted step attenuator. Each output bit enables one stage. Bit 0 is the 0.25 dB stage and each higher bit doubles the weight, up to 16 dB on bit 6. The total attenuation is the sum of the stages that are enabled. All control pins come from off-chip and are sampled by a fast system clock.

A mode pin selects the control source. When the mode pin is high, a three-wire serial port (data, shift clock, latch enable) shifts a word in and commits it. When the mode pin is low, seven parallel data pins set the word, either transparently or through a hold latch.

The latch-enable pin has several jobs. It gates the shift clock, it chooses between transparent and held parallel operation, and it triggers the serial commit. The output register comes out of reset at maximum attenuation.

Top module: `step_atten_ctrl`

## Requirements
- R1: The mode pin high selects serial control and low selects parallel control. While in serial mode, changes on the parallel pins do not reach the output.
- R2: In serial mode with latch enable low, each rising shift-clock edge appends the data pin into the word. The first bit sent ends up as bit 6 (16 dB) and the last bit sent as bit 0 (0.25 dB).
- R3: While latch enable is high, shift-clock edges leave the held serial word unchanged.
- R4: In serial mode, a rising edge of latch enable copies the shift word to the output. At no other time does the output change in serial mode.
- R5: In parallel mode with latch enable high, the output follows the parallel pins, a few system clocks later.
- R6: In parallel mode with latch enable low, the output keeps the value the parallel pins had when latch enable fell. Later changes on the parallel pins are ignored.
- R7: After reset, the output is all ones (31.75 dB) until the first latch event.
- R8: When more than seven shift edges arrive before the commit, only the last seven bits sent are kept.
- R9: A change of mode leaves the output unchanged until a latch event of the new mode occurs.
- R10: The output word is an unsigned count of 0.25 dB units, with bit i weighing 2^i quarter-dB. All zeros is the minimum-loss state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ser_i | input | 1 | 1 = serial control, 0 = parallel control |
| ser_data_i | input | 1 | Serial data pin |
| ser_clk_i | input | 1 | Serial shift clock pin |
| latch_en_i | input | 1 | Latch enable pin |
| par_word_i | input | 7 | Parallel attenuation word pins |
| atten_o | output | 7 | Registered stage-enable word, bit i = 2^i x 0.25 dB |

## Verification
Several behaviours are checked by assertions on every cycle:
- a high latch enable or parallel mode freezes the shift word;
- in serial mode, the output moves only on a latch-enable rise, and then to the shift word;
- in parallel mode, the output follows the pins with latch enable high and holds with it low.

The following can only be shown by the bench's scenarios, because they depend on whole sequences:
- the bit order across a seven-edge frame;
- truncation to the last seven bits;
- the reset default;
- the absence of any effect from mode switches.

The bench sweeps all 128 words through both the transparent parallel path and the serial path.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int ATT_BITS   = 7;
  localparam int SYNC_DEPTH = 2;
  typedef logic [ATT_BITS-1:0] att_word_t;
  localparam att_word_t ATT_MAX = '1;
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_nxt;

  always_comb begin
    stg_nxt[0] = d_i;
    for (int k = 1; k < STAGES; k++) stg_nxt[k] = stg_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_nxt;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/atten_edge.sv
module atten_edge #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~dly_q;
endmodule

// File: rtl/atten_shift.sv
module atten_shift
  import atten_pkg::*;
#(
  parameter int NBITS = ATT_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_mode_i,
  input  logic             le_i,
  input  logic             sclk_rise_i,
  input  logic             sdata_i,
  output logic [NBITS-1:0] word_o
);
  logic [NBITS-1:0] sr_q;
  logic [NBITS-1:0] sr_nxt;
  logic             sh_en;

  assign sh_en = ser_mode_i & ~le_i & sclk_rise_i;

  always_comb begin
    sr_nxt = sr_q;
    if (sh_en) sr_nxt = {sr_q[NBITS-2:0], sdata_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_nxt;
  end

  assign word_o = sr_q;

  assert_le_freezes_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    le_i |=> $stable(sr_q));
  assert_par_mode_no_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_mode_i |=> $stable(sr_q));
  assert_idle_no_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise_i |=> $stable(sr_q));
endmodule

// File: rtl/atten_latch.sv
module atten_latch
  import atten_pkg::*;
#(
  parameter int NBITS = ATT_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_mode_i,
  input  logic             le_i,
  input  logic             le_rise_i,
  input  logic [NBITS-1:0] par_i,
  input  logic [NBITS-1:0] shift_i,
  output logic [NBITS-1:0] q_o
);
  logic [NBITS-1:0] q_q;
  logic [NBITS-1:0] q_nxt;
  logic             ld_ser;
  logic             ld_par;

  assign ld_ser = ser_mode_i & le_rise_i;
  assign ld_par = ~ser_mode_i & le_i;

  always_comb begin
    q_nxt = q_q;
    if (ld_ser)      q_nxt = shift_i;
    else if (ld_par) q_nxt = par_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '1;
    else        q_q <= q_nxt;
  end

  assign q_o = q_q;

  assert_serial_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode_i && le_rise_i) |=> (q_q == $past(shift_i)));
  assert_serial_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode_i && !le_rise_i) |=> $stable(q_q));
  assert_par_transparent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode_i && le_i) |=> (q_q == $past(par_i)));
  assert_par_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode_i && !le_i) |=> $stable(q_q));
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import atten_pkg::*;
#(
  parameter int NBITS = ATT_BITS,
  parameter int SYNC  = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ser_i,
  input  logic             ser_data_i,
  input  logic             ser_clk_i,
  input  logic             latch_en_i,
  input  logic [NBITS-1:0] par_word_i,
  output logic [NBITS-1:0] atten_o
);
  localparam int NCTL = 4;

  logic [NCTL-1:0]  ctl_s;
  logic [NBITS-1:0] par_s;
  logic [1:0]       rise;
  logic [NBITS-1:0] shift_word;
  logic             mode_s, sdata_s, sclk_s, le_s;

  atten_sync #(.WIDTH(NCTL), .STAGES(SYNC)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({mode_ser_i, ser_data_i, ser_clk_i, latch_en_i}),
    .q_o(ctl_s)
  );

  atten_sync #(.WIDTH(NBITS), .STAGES(SYNC)) u_par_sync (
    .clk(clk), .rst_n(rst_n), .d_i(par_word_i), .q_o(par_s)
  );

  assign {mode_s, sdata_s, sclk_s, le_s} = ctl_s;

  atten_edge #(.WIDTH(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i({sclk_s, le_s}), .rise_o(rise)
  );

  atten_shift #(.NBITS(NBITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .ser_mode_i(mode_s), .le_i(le_s),
    .sclk_rise_i(rise[1]), .sdata_i(sdata_s), .word_o(shift_word)
  );

  atten_latch #(.NBITS(NBITS)) u_latch (
    .clk(clk), .rst_n(rst_n), .ser_mode_i(mode_s), .le_i(le_s),
    .le_rise_i(rise[0]), .par_i(par_s), .shift_i(shift_word), .q_o(atten_o)
  );
endmodule

// File: tb/step_atten_ctrl_bench.sv
module step_atten_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0, sdata = 1'b0, sclk = 1'b0, le = 1'b0;
  logic [6:0] par = '0;
  logic [6:0] atten;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  step_atten_ctrl u_step_atten_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_ser_i(mode), .ser_data_i(sdata),
    .ser_clk_i(sclk), .latch_en_i(le), .par_word_i(par), .atten_o(atten)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [6:0] exp);
    n_vec++;
    if (atten !== exp) begin
      n_bad++;
      $display("FAIL %s: atten=%02h expected=%02h", req, atten, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdata = b; step(2);
    sclk = 1'b1; step(3);
    sclk = 1'b0; step(2);
  endtask

  task automatic shift_word(input logic [6:0] w);
    for (int i = 6; i >= 0; i--) shift_bit(w[i]);
  endtask

  function automatic int quarter_db(input logic [6:0] w);
    int s = 0;
    for (int i = 0; i < 7; i++) if (w[i]) s += (1 << i);
    return s;
  endfunction

  initial begin
    step(3);
    rst_n = 1'b1;
    step(6);
    check("R7 reset default", 7'h7F);
    if (quarter_db(atten) != 127) begin
      n_bad++; $display("FAIL R7: qdB=%0d expected=127", quarter_db(atten));
    end

    // R5/R10 exhaustive transparent parallel sweep
    le = 1'b1;
    for (int w = 0; w < 128; w++) begin
      par = w[6:0]; step(5);
      check("R5 transparent", w[6:0]);
    end
    for (int i = 0; i < 7; i++) begin
      par = 7'(1 << i); step(5);
      n_vec++;
      if (quarter_db(atten) != (1 << i)) begin
        n_bad++;
        $display("FAIL R10: qdB=%0d expected=%0d", quarter_db(atten), 1 << i);
      end
    end

    // R6 latched parallel
    par = 7'h15; step(5);
    le = 1'b0; step(5);
    par = 7'h6A; step(6);
    check("R6 hold at fall", 7'h15);
    le = 1'b1; step(5);
    check("R6 pass when high", 7'h6A);
    le = 1'b0; step(4);

    // R9 parallel -> serial with latch enable low
    mode = 1'b1; step(6);
    check("R9 mode to serial no change", 7'h6A);
    // R1 parallel pins ignored in serial mode
    par = 7'h03; step(6);
    check("R1 parallel ignored", 7'h6A);

    // R2/R4 exhaustive serial sweep
    for (int w = 0; w < 128; w++) begin
      logic [6:0] prev;
      prev = atten;
      shift_word(w[6:0]);
      check("R4 no change before commit", prev);
      le = 1'b1; step(5);
      check("R2 serial word", w[6:0]);
      le = 1'b0; step(3);
    end

    // R3 edges with latch enable high are blocked
    shift_word(7'h4B);
    le = 1'b1; step(5);
    check("R2 load 4B", 7'h4B);
    for (int i = 0; i < 7; i++) shift_bit(~i[0]);
    le = 1'b0; step(4);
    le = 1'b1; step(5);
    check("R3 shift blocked", 7'h4B);
    le = 1'b0; step(3);

    // R8 over-long frame keeps last seven bits
    shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1);
    shift_word(7'h25);
    le = 1'b1; step(5);
    check("R8 last seven", 7'h25);
    le = 1'b0; step(3);

    // R9 serial -> parallel with latch enable low
    par = 7'h5C; mode = 1'b0; step(6);
    check("R9 mode to parallel no change", 7'h25);
    le = 1'b1; step(5);
    check("R9 parallel latch event", 7'h5C);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule